// File: doc/BRIEF.md
# Prefix Pipeline Selector

This block sits at the entry of a lookup engine that splits its routing trie into several disjoint subtrees and gives each subtree its own search pipeline. Every incoming address is steered by its leading `SEL_BITS` bits. Those bits index a direct-mapped selection table. A valid entry names the pipeline that owns the subtree and gives the root pointer of that subtree inside the pipeline. The longest-prefix search then runs only in that one pipeline. An invalid entry means that no subtree hangs below those leading bits.

Prefixes shorter than `SEL_BITS` bits cannot be placed in any one subtree, so the selector resolves them itself. It keeps a small bitmap trie with one valid flag and one next hop per node for every length from 0 to `SEL_BITS-1`. The longest matching node is reported next to the steering result as a fallback next hop. A downstream stage uses it only when its pipeline finds nothing longer. The selector accepts one lookup per clock and answers after a fixed two-cycle latency. A single write port loads both the table and the bitmap.

Top module: `prefix_pipe_selector`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `out_valid` and every bit of `pipe_valid` are 0. After reset, every selection entry and every bitmap node is empty, so a lookup reports `subtree_hit`=0 and `fb_hit`=0.
- R2: A lookup presented with `in_valid` in cycle N produces exactly one result with `out_valid`=1 in cycle N+2. Lookups may arrive in consecutive cycles, and `out_valid` is never raised without such a lookup.
- R3: The selection entry used is the one indexed by `in_addr[ADDR_W-1 -: SEL_BITS]`. The remaining low address bits have no effect on steering.
- R4: When the indexed entry is valid, `subtree_hit`=1, `out_pipe_id` and `out_root` carry the stored id and root, and exactly one bit of `pipe_valid` is 1: bit number `out_pipe_id`. When `out_valid` is 0, `pipe_valid` is all zeros.
- R5: When the indexed entry is invalid, `subtree_hit`=0, `pipe_valid`, `out_pipe_id` and `out_root` are 0, and the result is still delivered.
- R6: Bitmap node index for a length-L prefix p (0 ≤ L < `SEL_BITS`) is (1<<L)|p, where p is the leading L address bits, so node 1 is the zero-length default. The fallback is the valid node with the largest L along the address: `fb_hit`=1, `fb_len`=L, `fb_nh` its next hop. A write to node index 0 has no effect.
- R7: When no node along the address is valid, `fb_hit`, `fb_len` and `fb_nh` are 0.
- R8: Steering and fallback are independent. A result may show a subtree hit, a fallback hit, both or neither.
- R9: A configuration write and a lookup to the same entry or node in the same cycle give the lookup the old contents. The next lookup sees the new contents.
- R10: A selection-table write (`cfg_tgt`=0) with `cfg_valid`=1 and `cfg_pipe` ≥ `P` is dropped, and the entry keeps its previous contents. A write with `cfg_tgt`=1 targets the bitmap node `cfg_idx`.
- R11: `out_addr` equals the `in_addr` of the lookup whose result is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Lookup request this cycle |
| in_addr | input | ADDR_W | Address to steer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tgt | input | 1 | 0 = selection table, 1 = short-prefix bitmap |
| cfg_idx | input | SEL_BITS | Table entry or bitmap node index |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_pipe | input | PID_W | Pipeline id for a table entry |
| cfg_root | input | ROOT_W | Subtree root pointer for a table entry |
| cfg_nh | input | NH_W | Next hop for a bitmap node |
| out_valid | output | 1 | Result valid |
| pipe_valid | output | P | One-hot start strobe per pipeline |
| out_addr | output | ADDR_W | Address forwarded with the result |
| out_pipe_id | output | PID_W | Chosen pipeline |
| out_root | output | ROOT_W | Root pointer in the chosen pipeline |
| subtree_hit | output | 1 | Indexed selection entry was valid |
| fb_hit | output | 1 | A short prefix matched |
| fb_len | output | LEN_W | Length of the matched short prefix |
| fb_nh | output | NH_W | Next hop of the matched short prefix |

## Verification
The bench builds the selector with `ADDR_W`=16, `SEL_BITS`=4 and `P`=3. A 16-entry table and a 15-node bitmap make every entry and every short length from 0 to 3 easy to reach from directed and pseudo-random traffic. Because three pipelines need a 2-bit id, id value 3 exists on the write port, so the drop rule for out-of-range ids can be tested. Short data widths of 5 and 6 bits still let each stored root and next hop differ from its neighbours, so a wrong index shows up as a value mismatch.

// File: rtl/pps_pkg.sv
package pps_pkg;

   typedef enum logic {
      TGT_SELTAB = 1'b0,
      TGT_BITMAP = 1'b1
   } cfg_tgt_e;

   function automatic int len_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pps_sel_table.sv
module pps_sel_table #(
   parameter int SEL_BITS = 8,
   parameter int P        = 4,
   parameter int ROOT_W   = 12,
   localparam int PID_W   = $clog2(P),
   localparam int DEPTH   = 1 << SEL_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEL_BITS-1:0] wr_idx,
   input  logic                wr_valid,
   input  logic [PID_W-1:0]    wr_pid,
   input  logic [ROOT_W-1:0]   wr_root,
   input  logic [SEL_BITS-1:0] rd_idx,
   output logic                rd_valid_q,
   output logic [PID_W-1:0]    rd_pid_q,
   output logic [ROOT_W-1:0]   rd_root_q
);

   logic              ent_v    [DEPTH];
   logic [PID_W-1:0]  ent_pid  [DEPTH];
   logic [ROOT_W-1:0] ent_root [DEPTH];

   // a valid entry must point at an existing pipeline
   logic wr_legal;
   assign wr_legal = !wr_valid || ({1'b0, wr_pid} < (PID_W+1)'(P));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) begin
            ent_v[e]    <= 1'b0;
            ent_pid[e]  <= '0;
            ent_root[e] <= '0;
         end
         rd_valid_q <= 1'b0;
         rd_pid_q   <= '0;
         rd_root_q  <= '0;
      end else begin
         if (wr_en && wr_legal) begin
            ent_v[wr_idx]    <= wr_valid;
            ent_pid[wr_idx]  <= wr_pid;
            ent_root[wr_idx] <= wr_root;
         end
         // read sees pre-write contents in a colliding cycle
         rd_valid_q <= ent_v[rd_idx];
         rd_pid_q   <= ent_pid[rd_idx];
         rd_root_q  <= ent_root[rd_idx];
      end
   end

endmodule

// File: rtl/pps_short_bitmap.sv
module pps_short_bitmap #(
   parameter int SEL_BITS = 8,
   parameter int NH_W     = 8,
   localparam int DEPTH   = 1 << SEL_BITS
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SEL_BITS-1:0]            wr_idx,
   input  logic                           wr_valid,
   input  logic [NH_W-1:0]                wr_nh,
   input  logic [SEL_BITS-1:0]            rd_top,
   output logic [SEL_BITS-1:0]            hit_q,
   output logic [SEL_BITS-1:0][NH_W-1:0]  nh_q
);

   logic            node_v  [DEPTH];
   logic [NH_W-1:0] node_nh [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < DEPTH; n++) begin
            node_v[n]  <= 1'b0;
            node_nh[n] <= '0;
         end
      end else if (wr_en && (wr_idx != '0)) begin
         node_v[wr_idx]  <= wr_valid;
         node_nh[wr_idx] <= wr_nh;
      end
   end

   logic [SEL_BITS-1:0]           rd_hit;
   logic [SEL_BITS-1:0][NH_W-1:0] rd_nh;

   // one node per prefix length, heap-ordered: (1<<L) | leading L bits
   for (genvar L = 0; L < SEL_BITS; L++) begin : g_len
      logic [SEL_BITS-1:0] node;
      if (L == 0) begin : g_root
         assign node = SEL_BITS'(1);
      end else begin : g_deep
         assign node = SEL_BITS'(1 << L) | SEL_BITS'(rd_top[SEL_BITS-1 -: L]);
      end
      assign rd_hit[L] = node_v[node];
      assign rd_nh[L]  = node_nh[node];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q <= '0;
         nh_q  <= '0;
      end else begin
         hit_q <= rd_hit;
         nh_q  <= rd_nh;
      end
   end

endmodule

// File: rtl/pps_longest_pick.sv
module pps_longest_pick #(
   parameter int SEL_BITS = 8,
   parameter int NH_W     = 8,
   parameter int LEN_W    = 3
) (
   input  logic [SEL_BITS-1:0]           hit,
   input  logic [SEL_BITS-1:0][NH_W-1:0] nh,
   output logic                          best_hit,
   output logic [LEN_W-1:0]              best_len,
   output logic [NH_W-1:0]               best_nh
);

   always_comb begin
      best_hit = 1'b0;
      best_len = '0;
      best_nh  = '0;
      for (int L = 0; L < SEL_BITS; L++) begin
         if (hit[L]) begin
            best_hit = 1'b1;
            best_len = LEN_W'(L);
            best_nh  = nh[L];
         end
      end
   end

endmodule

// File: rtl/prefix_pipe_selector.sv
module prefix_pipe_selector #(
   parameter int ADDR_W   = 32,
   parameter int SEL_BITS = 8,
   parameter int P        = 4,
   parameter int ROOT_W   = 12,
   parameter int NH_W     = 8,
   parameter bit FB_EN    = 1'b1,
   localparam int PID_W   = $clog2(P),
   localparam int LEN_W   = pps_pkg::len_width(SEL_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic                cfg_we,
   input  logic                cfg_tgt,
   input  logic [SEL_BITS-1:0] cfg_idx,
   input  logic                cfg_valid,
   input  logic [PID_W-1:0]    cfg_pipe,
   input  logic [ROOT_W-1:0]   cfg_root,
   input  logic [NH_W-1:0]     cfg_nh,
   output logic                out_valid,
   output logic [P-1:0]        pipe_valid,
   output logic [ADDR_W-1:0]   out_addr,
   output logic [PID_W-1:0]    out_pipe_id,
   output logic [ROOT_W-1:0]   out_root,
   output logic                subtree_hit,
   output logic                fb_hit,
   output logic [LEN_W-1:0]    fb_len,
   output logic [NH_W-1:0]     fb_nh
);

   import pps_pkg::*;

   // elaboration-time parameter checks
   if (P < 2) begin : g_bad_p
      $error("prefix_pipe_selector: P must be at least 2");
   end
   if (SEL_BITS < 1 || SEL_BITS >= ADDR_W) begin : g_bad_sel
      $error("prefix_pipe_selector: SEL_BITS must lie in 1..ADDR_W-1");
   end
   if (SEL_BITS > 12) begin : g_big_sel
      $error("prefix_pipe_selector: SEL_BITS above 12 makes flop tables too large");
   end

   logic [SEL_BITS-1:0] lead;
   assign lead = in_addr[ADDR_W-1 -: SEL_BITS];

   // ---------------- stage 1: table and bitmap reads
   logic              s1_valid;
   logic [ADDR_W-1:0] s1_addr;
   logic              s1_ent_v;
   logic [PID_W-1:0]  s1_pid;
   logic [ROOT_W-1:0] s1_root;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_addr  <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_addr  <= in_addr;
      end
   end

   pps_sel_table #(
      .SEL_BITS (SEL_BITS),
      .P        (P),
      .ROOT_W   (ROOT_W)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we && (cfg_tgt == TGT_SELTAB)),
      .wr_idx     (cfg_idx),
      .wr_valid   (cfg_valid),
      .wr_pid     (cfg_pipe),
      .wr_root    (cfg_root),
      .rd_idx     (lead),
      .rd_valid_q (s1_ent_v),
      .rd_pid_q   (s1_pid),
      .rd_root_q  (s1_root)
   );

   logic             pk_hit;
   logic [LEN_W-1:0] pk_len;
   logic [NH_W-1:0]  pk_nh;

   if (FB_EN) begin : g_fb
      logic [SEL_BITS-1:0]           s1_bm_hit;
      logic [SEL_BITS-1:0][NH_W-1:0] s1_bm_nh;

      pps_short_bitmap #(
         .SEL_BITS (SEL_BITS),
         .NH_W     (NH_W)
      ) u_bitmap (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (cfg_we && (cfg_tgt == TGT_BITMAP)),
         .wr_idx   (cfg_idx),
         .wr_valid (cfg_valid),
         .wr_nh    (cfg_nh),
         .rd_top   (lead),
         .hit_q    (s1_bm_hit),
         .nh_q     (s1_bm_nh)
      );

      pps_longest_pick #(
         .SEL_BITS (SEL_BITS),
         .NH_W     (NH_W),
         .LEN_W    (LEN_W)
      ) u_pick (
         .hit      (s1_bm_hit),
         .nh       (s1_bm_nh),
         .best_hit (pk_hit),
         .best_len (pk_len),
         .best_nh  (pk_nh)
      );
   end else begin : g_no_fb
      assign pk_hit = 1'b0;
      assign pk_len = '0;
      assign pk_nh  = '0;
   end

   // ---------------- stage 2: one-hot steering and result registers
   logic [P-1:0] pipe_dec;
   for (genvar p = 0; p < P; p++) begin : g_dec
      assign pipe_dec[p] = s1_ent_v && (s1_pid == PID_W'(p));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         pipe_valid  <= '0;
         out_addr    <= '0;
         out_pipe_id <= '0;
         out_root    <= '0;
         subtree_hit <= 1'b0;
         fb_hit      <= 1'b0;
         fb_len      <= '0;
         fb_nh       <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            pipe_valid  <= pipe_dec;
            out_addr    <= s1_addr;
            subtree_hit <= s1_ent_v;
            out_pipe_id <= s1_ent_v ? s1_pid  : '0;
            out_root    <= s1_ent_v ? s1_root : '0;
            fb_hit      <= pk_hit;
            fb_len      <= pk_len;
            fb_nh       <= pk_nh;
         end else begin
            pipe_valid  <= '0;
            out_addr    <= '0;
            subtree_hit <= 1'b0;
            out_pipe_id <= '0;
            out_root    <= '0;
            fb_hit      <= 1'b0;
            fb_len      <= '0;
            fb_nh       <= '0;
         end
      end
   end

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
   parameter int ADDR_W = 32,
   parameter int P      = 4,
   parameter int PID_W  = 2,
   parameter int NH_W   = 8,
   parameter int LEN_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ADDR_W-1:0] in_addr,
   input logic              out_valid,
   input logic [P-1:0]      pipe_valid,
   input logic [ADDR_W-1:0] out_addr,
   input logic [PID_W-1:0]  out_pipe_id,
   input logic              subtree_hit,
   input logic              fb_hit,
   input logic [LEN_W-1:0]  fb_len,
   input logic [NH_W-1:0]   fb_nh
);

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && pipe_valid == '0));

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pipe_valid) == ((out_valid && subtree_hit) ? 1 : 0));

   assert_strobe_matches_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && subtree_hit) |-> (((pipe_valid >> out_pipe_id) & P'(1)) == P'(1)));

   assert_fb_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !fb_hit) |-> (fb_nh == '0 && fb_len == '0));

   assert_addr_forward_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_addr == $past(in_addr, 2)));

endmodule

bind prefix_pipe_selector pps_checker #(
   .ADDR_W (ADDR_W),
   .P      (P),
   .PID_W  (PID_W),
   .NH_W   (NH_W),
   .LEN_W  (LEN_W)
) u_pps_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_addr     (in_addr),
   .out_valid   (out_valid),
   .pipe_valid  (pipe_valid),
   .out_addr    (out_addr),
   .out_pipe_id (out_pipe_id),
   .subtree_hit (subtree_hit),
   .fb_hit      (fb_hit),
   .fb_len      (fb_len),
   .fb_nh       (fb_nh)
);

// File: tb/prefix_pipe_selector_tb_top.sv
`timescale 1ns/1ps
module prefix_pipe_selector_tb_top;

   localparam int AW = 16;
   localparam int SB = 4;
   localparam int NP = 3;
   localparam int RW = 5;
   localparam int NW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic          cfg_we = 1'b0;
   logic          cfg_tgt = 1'b0;
   logic [SB-1:0] cfg_idx = '0;
   logic          cfg_valid = 1'b0;
   logic [1:0]    cfg_pipe = '0;
   logic [RW-1:0] cfg_root = '0;
   logic [NW-1:0] cfg_nh = '0;
   logic          out_valid;
   logic [NP-1:0] pipe_valid;
   logic [AW-1:0] out_addr;
   logic [1:0]    out_pipe_id;
   logic [RW-1:0] out_root;
   logic          subtree_hit;
   logic          fb_hit;
   logic [1:0]    fb_len;
   logic [NW-1:0] fb_nh;

   always #2.5 clk = ~clk;

   prefix_pipe_selector #(
      .ADDR_W (AW), .SEL_BITS (SB), .P (NP), .ROOT_W (RW), .NH_W (NW), .FB_EN (1'b1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_addr (in_addr),
      .cfg_we (cfg_we), .cfg_tgt (cfg_tgt), .cfg_idx (cfg_idx), .cfg_valid (cfg_valid),
      .cfg_pipe (cfg_pipe), .cfg_root (cfg_root), .cfg_nh (cfg_nh),
      .out_valid (out_valid), .pipe_valid (pipe_valid), .out_addr (out_addr),
      .out_pipe_id (out_pipe_id), .out_root (out_root), .subtree_hit (subtree_hit),
      .fb_hit (fb_hit), .fb_len (fb_len), .fb_nh (fb_nh)
   );

   typedef struct {
      int            due;
      string         sc;
      logic [AW-1:0] addr;
      logic          sub;
      logic [1:0]    pid;
      logic [RW-1:0] root;
      logic [NP-1:0] pv;
      logic          fbh;
      logic [1:0]    fbl;
      logic [NW-1:0] fbn;
   } exp_t;

   exp_t q[$];
   exp_t mon_e;
   int   n_cmp = 0;
   int   n_bad = 0;
   int   cyc = 0;
   bit   mon_on = 1'b0;
   bit   finished = 1'b0;

   // reference model of the stored configuration
   bit          tv    [16];
   bit [1:0]    tpid  [16];
   bit [RW-1:0] troot [16];
   bit          bv    [16];
   bit [NW-1:0] bnh   [16];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   function automatic exp_t predict(input logic [AW-1:0] a, input string sc);
      exp_t e;
      int   top;
      top    = int'(a[AW-1 -: SB]);
      e.due  = 0;
      e.sc   = sc;
      e.addr = a;
      e.sub  = tv[top];
      e.pid  = tv[top] ? tpid[top] : 2'd0;
      e.root = tv[top] ? troot[top] : '0;
      e.pv   = tv[top] ? NP'(1 << tpid[top]) : '0;
      e.fbh  = 1'b0;
      e.fbl  = 2'd0;
      e.fbn  = '0;
      for (int L = 0; L < SB; L++) begin
         int n;
         n = (1 << L) | (top >> (SB - L));
         if (bv[n]) begin
            e.fbh = 1'b1;
            e.fbl = 2'(L);
            e.fbn = bnh[n];
         end
      end
      return e;
   endfunction

   // one cycle of stimulus, entered and left just after a falling edge
   task automatic step(input string sc, input bit lk, input logic [AW-1:0] a,
                       input bit wr, input bit tgt, input int idx, input bit v,
                       input int pid, input int root, input int nh);
      exp_t e;
      in_valid  = lk;
      in_addr   = a;
      cfg_we    = wr;
      cfg_tgt   = tgt;
      cfg_idx   = SB'(idx);
      cfg_valid = v;
      cfg_pipe  = 2'(pid);
      cfg_root  = RW'(root);
      cfg_nh    = NW'(nh);
      if (lk) begin
         e     = predict(a, sc);   // old contents (R9)
         e.due = cyc + 2;
         q.push_back(e);
      end
      if (wr) begin
         if (!tgt) begin
            if (!v || pid < NP) begin   // R10 drop rule
               tv[idx]    = v;
               tpid[idx]  = 2'(pid);
               troot[idx] = RW'(root);
            end
         end else if (idx != 0) begin
            bv[idx]  = v;
            bnh[idx] = NW'(nh);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      cfg_we   = 1'b0;
   endtask

   task automatic look(input string sc, input logic [AW-1:0] a);
      step(sc, 1'b1, a, 1'b0, 1'b0, 0, 1'b0, 0, 0, 0);
   endtask
   task automatic wtab(input int idx, input bit v, input int pid, input int root);
      step("cfg", 1'b0, '0, 1'b1, 1'b0, idx, v, pid, root, 0);
   endtask
   task automatic wbm(input int idx, input bit v, input int nh);
      step("cfg", 1'b0, '0, 1'b1, 1'b1, idx, v, 0, 0, nh);
   endtask
   task automatic idle();
      @(negedge clk);
   endtask

   // monitor: pops the scoreboard when a result is due
   always @(negedge clk) begin
      if (mon_on) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            mon_e = q.pop_front();
            chk(out_valid === 1'b1, "R2", {mon_e.sc, " out_valid"}, out_valid, 1);
            chk(out_addr == mon_e.addr, "R11", {mon_e.sc, " out_addr"}, out_addr, mon_e.addr);
            chk(subtree_hit == mon_e.sub, "R5", {mon_e.sc, " subtree_hit"}, subtree_hit, mon_e.sub);
            chk(pipe_valid == mon_e.pv, "R4", {mon_e.sc, " pipe_valid"}, pipe_valid, mon_e.pv);
            chk(out_pipe_id == mon_e.pid, "R4", {mon_e.sc, " out_pipe_id"}, out_pipe_id, mon_e.pid);
            chk(out_root == mon_e.root, "R4", {mon_e.sc, " out_root"}, out_root, mon_e.root);
            chk(fb_hit == mon_e.fbh, "R6", {mon_e.sc, " fb_hit"}, fb_hit, mon_e.fbh);
            chk(fb_len == mon_e.fbl, "R6", {mon_e.sc, " fb_len"}, fb_len, mon_e.fbl);
            chk(fb_nh == mon_e.fbn, "R6", {mon_e.sc, " fb_nh"}, fb_nh, mon_e.fbn);
         end else if (out_valid !== 1'b0 || pipe_valid != '0) begin
            chk(1'b0, "R2", "result without a lookup", out_valid, 0);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : driver
      logic [31:0] lf;
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // R1: idle outputs while in reset
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      chk(pipe_valid == '0, "R1", "pipe_valid in reset", pipe_valid, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      idle();

      // R1: empty tables after reset; R7 no fallback
      look("R1", 16'h1234);
      look("R7", 16'hFFFF);

      wtab(1, 1'b1, 2, 7);
      wtab(10, 1'b1, 0, 3);
      wtab(15, 1'b1, 1, 31);
      // R10: out-of-range pipeline ids are dropped
      wtab(5, 1'b1, 3, 9);
      wtab(10, 1'b1, 3, 1);
      look("R10", 16'h5ABC);
      look("R10", 16'hA000);

      // R3: low bits do not steer; R2 back to back
      look("R3", 16'h1000);
      look("R3", 16'h1FFF);
      look("R3", 16'hA555);
      look("R3", 16'hF00F);

      // short prefixes: default, 1*, 01*, 101*; node 0 write dropped
      wbm(1, 1'b1, 1);
      wbm(3, 1'b1, 2);
      wbm(5, 1'b1, 3);
      wbm(13, 1'b1, 4);
      wbm(0, 1'b1, 9);
      for (int t = 0; t < 16; t++) look("R6", {4'(t), 12'h3C5});

      // R8: fallback with and without a subtree
      look("R8", 16'h2000);
      look("R8", 16'hD000);
      look("R8", 16'hA000);

      // R9: same-cycle write and lookup see old contents
      step("R9", 1'b1, 16'hA123, 1'b1, 1'b0, 10, 1'b1, 1, 20, 0);
      look("R9", 16'hA123);
      step("R9", 1'b1, 16'hB000, 1'b1, 1'b1, 13, 1'b1, 0, 0, 7);
      look("R9", 16'hB000);

      // R5: invalidated entry, lookups with idle gaps
      wtab(1, 1'b0, 0, 0);
      look("R5", 16'h1000);
      idle();
      look("R5", 16'h1234);
      idle();
      idle();
      wbm(1, 1'b0, 0);
      look("R7", 16'h0000);

      // pseudo-random mix of lookups and writes
      lf = 32'hACE1_2468;
      for (int k = 0; k < 600; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         r  = lf ^ {lf[15:0], lf[31:16]};
         step("mix", r[0] | r[1], r[31:16], r[2] & r[3], r[4], int'(r[8:5]),
              r[9] | r[10], int'(r[12:11]), int'(r[17:13]), int'(r[23:18]));
      end

      repeat (4) idle();
      chk(q.size() == 0, "R2", "results still owed", q.size(), 0);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule